// File: doc/BRIEF.md
# Station Address Boot Loader

This block runs once after every reset and fills a 48-bit station (MAC) address register from a serial configuration memory. It does not drive the serial wires. Instead it issues word reads through a request/acknowledge port to a separate word reader. It first reads a signature word. If the signature is correct, it reads three address words, turns them into six bytes and checks that the result is a usable unicast address. Only then does it replace the default address held since reset.

Any fault leaves the address at its reset default. The fault can be a missing signature or an address that is multicast or all zero. The block then reports which fault stopped it, so the surrounding logic can continue with the default. The outcome flags stay fixed until the next reset.

Top module: `mac_boot_loader`

## Requirements
- R1: While reset is asserted, and in the first clock after it is released, the outputs are as follows: `mac_addr` equals the `RESET_MAC` parameter, `mac_valid`, `done`, `sig_err` and `addr_err` are 0, and `rd_req` is 0. From the second clock after release, `rd_req` is 1 with `rd_addr` = 0.
- R2: A request holds `rd_req` high and `rd_addr` steady until a clock at which `rd_ack` is 1. `rd_data` is taken in that clock. `rd_ack` has no effect in a clock where `rd_req` is 0.
- R3: The word at address 0 is compared with 16'h8129. On a mismatch, the block raises `done` and `sig_err` and makes no further request. `mac_addr` keeps `RESET_MAC`.
- R4: On a match, the block reads words 7, 8 and 9 in that order, with exactly one accepted request each, so four reads in total.
- R5: In word 7+k, bits [7:0] become address byte 2k and bits [15:8] become byte 2k+1. Byte 0 sits at `mac_addr[47:40]` and byte 5 at `mac_addr[7:0]`.
- R6: The assembled address is valid when byte 0 bit 0 (`mac_addr[40]`) is 0 and at least one of the 48 bits is 1. A valid address is loaded into `mac_addr`, and `done` and `mac_valid` are raised.
- R7: An invalid address raises `done` and `addr_err` and leaves `mac_addr` at `RESET_MAC`.
- R8: On the address path, the outcome flags and `mac_addr` update two clocks after the clock in which the last word's `rd_ack` was applied, because one clock is spent on the check. On a signature mismatch they update one clock after the signature word's `rd_ack`.
- R9: While `done` is 1, exactly one of `mac_valid`, `sig_err` and `addr_err` is 1. Before `done`, all three are 0. `done`, the flags and `mac_addr` then hold with no further request until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | output | 1 | Word read request |
| rd_addr | output | AW (8) | Word address of the request |
| rd_ack | input | 1 | Read data valid, completes the request |
| rd_data | input | 16 | Word returned with `rd_ack` |
| mac_addr | output | 48 | Station address, byte 0 in the top bits |
| mac_valid | output | 1 | Address was loaded from memory |
| done | output | 1 | Boot sequence finished |
| sig_err | output | 1 | Finished on a signature mismatch |
| addr_err | output | 1 | Finished on a multicast or zero address |

## Verification
The bench keeps a behavioural model of the read sequence. It feeds the model the same acknowledge stream and compares every clock, using reader latencies of zero to several cycles. The corner cases it targets are these:
- A near-miss signature: a loader that compared only one byte would go on to load the address.
- A group-bit address and an all-zero address: a weak validity check would commit either of them.
- An address whose only set bit is in the last byte: a check that looked only at early bytes would reject it.
- Swapped word halves: the bench reads these out directly as a byte-reversed `mac_addr`.

Stray acknowledges while no request is pending, a reset in the middle of the address reads, and memory contents changed after completion show whether the block accepts unrequested data, fails to restart, or reads again after finishing.

// File: rtl/mbl_pkg.sv
package mbl_pkg;

    // Phases of the one-shot boot sequence
    typedef enum logic [2:0] {
        ST_START = 3'd0,
        ST_SIG   = 3'd1,
        ST_WORD  = 3'd2,
        ST_CHECK = 3'd3,
        ST_FIN   = 3'd4
    } mbl_state_e;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

endpackage

// File: rtl/mbl_seq.sv
module mbl_seq
    import mbl_pkg::*;
#(
    parameter int              AW        = 8,
    parameter int              NUM_WORDS = 3,
    parameter int              SIG_ADDR  = 0,
    parameter logic [15:0]     SIG_WORD  = 16'h8129,
    parameter int              MAC_BASE  = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_ack,
    input  logic [WORD_W-1:0]     rd_data,
    input  logic                  addr_ok,
    output logic                  rd_req,
    output logic [AW-1:0]         rd_addr,
    output logic                  word_we,
    output logic [((NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1)-1:0] word_idx,
    output logic                  commit,
    output logic                  done,
    output logic                  mac_valid,
    output logic                  sig_err,
    output logic                  addr_err
);

    localparam int IW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_WORDS - 1);

    typedef struct packed {
        mbl_state_e    st;
        logic [IW-1:0] idx;
        logic          ok;
        logic          serr;
        logic          aerr;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d   = seq_q;
        rd_req  = 1'b0;
        rd_addr = AW'(SIG_ADDR);
        word_we = 1'b0;
        commit  = 1'b0;
        unique case (seq_q.st)
            ST_START: begin
                seq_d.st = ST_SIG;
            end
            ST_SIG: begin
                rd_req = 1'b1;
                if (rd_ack) begin
                    if (rd_data == SIG_WORD) begin
                        seq_d.st  = ST_WORD;
                        seq_d.idx = '0;
                    end else begin
                        seq_d.st   = ST_FIN;
                        seq_d.serr = 1'b1;
                    end
                end
            end
            ST_WORD: begin
                rd_req  = 1'b1;
                rd_addr = AW'(MAC_BASE) + AW'(seq_q.idx);
                if (rd_ack) begin
                    word_we = 1'b1;
                    if (seq_q.idx == LAST_IDX) begin
                        seq_d.st = ST_CHECK;
                    end else begin
                        seq_d.idx = seq_q.idx + IW'(1);
                    end
                end
            end
            ST_CHECK: begin
                seq_d.st = ST_FIN;
                if (addr_ok) begin
                    commit   = 1'b1;
                    seq_d.ok = 1'b1;
                end else begin
                    seq_d.aerr = 1'b1;
                end
            end
            ST_FIN: begin
                seq_d = seq_q;
            end
            default: begin
                seq_d.st = ST_FIN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_START, idx: '0, ok: 1'b0, serr: 1'b0, aerr: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign word_idx  = seq_q.idx;
    assign done      = (seq_q.st == ST_FIN);
    assign mac_valid = seq_q.ok;
    assign sig_err   = seq_q.serr;
    assign addr_err  = seq_q.aerr;

endmodule

// File: rtl/mbl_unpack.sv
module mbl_unpack
    import mbl_pkg::*;
#(
    parameter int NUM_WORDS = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          word_we,
    input  logic [((NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1)-1:0] word_idx,
    input  logic [WORD_W-1:0]             rd_data,
    output logic [NUM_WORDS*WORD_W-1:0]   asm_o
);

    localparam int IW    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int MAC_W = NUM_WORDS * WORD_W;

    logic [NUM_WORDS-1:0] hit;
    logic [WORD_W-1:0]    swapped;
    logic [MAC_W-1:0]     asm_d, asm_q;

    // Low byte of each word is the earlier (more significant) address byte
    assign swapped = {rd_data[BYTE_W-1:0], rd_data[WORD_W-1:BYTE_W]};

    for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_hit
        assign hit[gi] = word_we && (word_idx == IW'(gi));
    end

    always_comb begin
        asm_d = asm_q;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (hit[i]) begin
                asm_d[MAC_W-1-WORD_W*i -: WORD_W] = swapped;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asm_q <= '0;
        end else begin
            asm_q <= asm_d;
        end
    end

    assign asm_o = asm_q;

endmodule

// File: rtl/mbl_check.sv
module mbl_check
    import mbl_pkg::*;
#(
    parameter int MAC_W = 48
) (
    input  logic [MAC_W-1:0] asm_i,
    output logic             addr_ok
);

    localparam int NBYTES = MAC_W / BYTE_W;

    logic [NBYTES-1:0] byte_nz;

    for (genvar gb = 0; gb < NBYTES; gb++) begin : g_nz
        assign byte_nz[gb] = |asm_i[BYTE_W*gb +: BYTE_W];
    end

    // Group bit is bit 0 of the first (most significant) byte
    assign addr_ok = !asm_i[MAC_W-BYTE_W] && (|byte_nz);

endmodule

// File: rtl/mac_boot_loader.sv
module mac_boot_loader
    import mbl_pkg::*;
#(
    parameter int                        AW        = 8,
    parameter int                        NUM_WORDS = 3,
    parameter int                        SIG_ADDR  = 0,
    parameter logic [15:0]               SIG_WORD  = 16'h8129,
    parameter int                        MAC_BASE  = 7,
    parameter logic [NUM_WORDS*16-1:0]   RESET_MAC = 48'h02_00_00_00_00_01
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic                       rd_req,
    output logic [AW-1:0]              rd_addr,
    input  logic                       rd_ack,
    input  logic [15:0]                rd_data,
    output logic [NUM_WORDS*16-1:0]    mac_addr,
    output logic                       mac_valid,
    output logic                       done,
    output logic                       sig_err,
    output logic                       addr_err
);

    localparam int MAC_W = NUM_WORDS * WORD_W;
    localparam int IW    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    logic             word_we;
    logic [IW-1:0]    word_idx;
    logic             commit;
    logic             addr_ok;
    logic [MAC_W-1:0] asm_w;
    logic [MAC_W-1:0] mac_d, mac_q;

    mbl_seq #(
        .AW        (AW),
        .NUM_WORDS (NUM_WORDS),
        .SIG_ADDR  (SIG_ADDR),
        .SIG_WORD  (SIG_WORD),
        .MAC_BASE  (MAC_BASE)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_ack    (rd_ack),
        .rd_data   (rd_data),
        .addr_ok   (addr_ok),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .word_we   (word_we),
        .word_idx  (word_idx),
        .commit    (commit),
        .done      (done),
        .mac_valid (mac_valid),
        .sig_err   (sig_err),
        .addr_err  (addr_err)
    );

    mbl_unpack #(
        .NUM_WORDS (NUM_WORDS)
    ) u_unpack (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_we  (word_we),
        .word_idx (word_idx),
        .rd_data  (rd_data),
        .asm_o    (asm_w)
    );

    mbl_check #(
        .MAC_W (MAC_W)
    ) u_check (
        .asm_i   (asm_w),
        .addr_ok (addr_ok)
    );

    always_comb begin
        mac_d = mac_q;
        if (commit) begin
            mac_d = asm_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mac_q <= RESET_MAC;
        end else begin
            mac_q <= mac_d;
        end
    end

    assign mac_addr = mac_q;

endmodule

// File: rtl/mbl_chk.sv
module mbl_chk #(
    parameter int AW       = 8,
    parameter int MAC_W    = 48,
    parameter int SIG_ADDR = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req,
    input logic [AW-1:0]    rd_addr,
    input logic             rd_ack,
    input logic [MAC_W-1:0] mac_addr,
    input logic             mac_valid,
    input logic             done,
    input logic             sig_err,
    input logic             addr_err
);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    // R3
    sig_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sig_err) |-> $past(rd_req && rd_ack && (rd_addr == AW'(SIG_ADDR))));

    // R9
    no_req_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req);

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(mac_addr)));

    // R9
    outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({mac_valid, sig_err, addr_err}) == 1));

    // R9
    quiet_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !(mac_valid || sig_err || addr_err));

    // R7
    mac_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mac_addr) |-> $rose(mac_valid));

    // R6
    mac_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mac_valid |-> (!mac_addr[MAC_W-8] && (mac_addr != '0)));

endmodule

bind mac_boot_loader mbl_chk #(
    .AW       (AW),
    .MAC_W    (MAC_W),
    .SIG_ADDR (SIG_ADDR)
) u_mbl_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_ack    (rd_ack),
    .mac_addr  (mac_addr),
    .mac_valid (mac_valid),
    .done      (done),
    .sig_err   (sig_err),
    .addr_err  (addr_err)
);

// File: tb/tb_mac_boot_loader.sv
module tb_mac_boot_loader;

    localparam logic [47:0] DEF_MAC = 48'h02_00_00_00_00_01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_ack = 1'b0;
    logic [15:0] rd_data = 16'h0;
    logic        rd_req;
    logic [7:0]  rd_addr;
    logic [47:0] mac_addr;
    logic        mac_valid, done, sig_err, addr_err;

    always #5 clk = ~clk;

    mac_boot_loader #(.RESET_MAC(DEF_MAC)) dut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .mac_addr(mac_addr),
        .mac_valid(mac_valid), .done(done), .sig_err(sig_err), .addr_err(addr_err)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    logic [15:0] mem [16];
    int lat = 0;
    bit stray = 1'b0;
    int cnt = 0;
    int ack_cyc = 0;
    int real_acks = 0;
    int done_cyc = -1;

    // behavioural reference model
    int          m_ph = 0;
    int          m_idx = 0;
    logic [7:0]  m_b [6];
    logic [47:0] m_mac = DEF_MAC;
    bit          m_v = 0, m_s = 0, m_a = 0, m_done = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_idx = 0; m_mac = DEF_MAC;
            m_v = 0; m_s = 0; m_a = 0; m_done = 0;
        end else begin
            case (m_ph)
                0: m_ph = 1;
                1: if (rd_ack) begin
                       if (rd_data == 16'h8129) begin m_ph = 2; m_idx = 0; end
                       else begin m_ph = 4; m_s = 1; m_done = 1; end
                   end
                2: if (rd_ack) begin
                       m_b[2*m_idx]   = rd_data[7:0];
                       m_b[2*m_idx+1] = rd_data[15:8];
                       if (m_idx == 2) m_ph = 3; else m_idx++;
                   end
                3: begin
                       if (m_b[0][0] == 1'b0 &&
                           {m_b[0], m_b[1], m_b[2], m_b[3], m_b[4], m_b[5]} != 48'h0) begin
                           m_mac = {m_b[0], m_b[1], m_b[2], m_b[3], m_b[4], m_b[5]};
                           m_v = 1;
                       end else begin
                           m_a = 1;
                       end
                       m_done = 1; m_ph = 4;
                   end
                default: ;
            endcase
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk("R2", "rd_req", 64'(rd_req), 64'(m_ph == 1 || m_ph == 2));
            if (m_ph == 1 || m_ph == 2)
                chk("R4", "rd_addr", 64'(rd_addr), 64'((m_ph == 1) ? 0 : 7 + m_idx));
            chk("R5", "mac_addr", 64'(mac_addr), 64'(m_mac));
            chk("R9", "flags", 64'({done, mac_valid, sig_err, addr_err}),
                64'({m_done, m_v, m_s, m_a}));
            if (done && done_cyc < 0) done_cyc = cyc;
        end
        // word reader responder
        if (rd_ack) begin
            rd_ack = 1'b0; rd_data = 16'hBEEF; cnt = 0;
        end else if (rst_n && rd_req) begin
            if (cnt >= lat) begin
                rd_ack = 1'b1; rd_data = mem[rd_addr[3:0]];
                ack_cyc = cyc; real_acks++;
            end else begin
                cnt++;
            end
        end else if (stray && (cyc % 5 == 0)) begin
            rd_ack = 1'b1; rd_data = 16'h8129;
        end
    end

    task automatic start_reset();
        @(posedge clk); #2;
        rst_n = 1'b0; rd_ack = 1'b0; cnt = 0; real_acks = 0; done_cyc = -1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset mac", 64'(mac_addr), 64'(DEF_MAC));
        chk("R1", "reset flags", 64'({rd_req, done, mac_valid, sig_err, addr_err}), 64'(0));
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "no request first cycle", 64'(rd_req), 64'(0));
        @(negedge clk);
        chk("R1", "first request", 64'({rd_req, rd_addr}), 64'({1'b1, 8'h00}));
    endtask

    task automatic run_case(input logic [15:0] w0, input logic [15:0] w7,
                            input logic [15:0] w8, input logic [15:0] w9,
                            input int l, input bit s, input logic [47:0] emac,
                            input bit ev, input bit es, input bit ea);
        for (int i = 0; i < 16; i++) mem[i] = 16'hDEAD;
        mem[0] = w0; mem[7] = w7; mem[8] = w8; mem[9] = w9;
        lat = l; stray = s;
        start_reset();
        for (int i = 0; i < 300 && !done; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(ev ? "R6" : (es ? "R3" : "R7"), "final mac", 64'(mac_addr), 64'(emac));
        chk(ev ? "R6" : (es ? "R3" : "R7"), "outcome",
            64'({done, mac_valid, sig_err, addr_err}), 64'({1'b1, ev, es, ea}));
        chk(es ? "R3" : "R4", "accepted reads", 64'(real_acks), 64'(es ? 1 : 4));
        chk("R8", "done lag", 64'(done_cyc - ack_cyc), 64'(es ? 1 : 2));
        // contents changed after completion: nothing may be re-read
        mem[0] = 16'h8129; mem[7] = 16'h7766; mem[8] = 16'h5544; mem[9] = 16'h3322;
        repeat (15) @(negedge clk);
        chk("R9", "hold after done", 64'({mac_addr, real_acks[3:0]}),
            64'({emac, 4'(es ? 1 : 4)}));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R5 R6: 00:11:22:33:44:55, zero-latency reader
        run_case(16'h8129, 16'h1100, 16'h3322, 16'h5544, 0, 0,
                 48'h001122334455, 1, 0, 0);
        // R2 R5: 02:AB:CD:EF:01:23, slow reader
        run_case(16'h8129, 16'hAB02, 16'hEFCD, 16'h2301, 3, 0,
                 48'h02ABCDEF0123, 1, 0, 0);
        // R3: byte-swapped signature
        run_case(16'h2981, 16'h1100, 16'h3322, 16'h5544, 1, 0,
                 DEF_MAC, 0, 1, 0);
        // R3: signature off by one bit
        run_case(16'h8128, 16'h1100, 16'h3322, 16'h5544, 0, 0,
                 DEF_MAC, 0, 1, 0);
        // R7: group bit set in byte 0
        run_case(16'h8129, 16'h2201, 16'h4433, 16'h6655, 2, 0,
                 DEF_MAC, 0, 0, 1);
        // R7: all-zero address
        run_case(16'h8129, 16'h0000, 16'h0000, 16'h0000, 0, 0,
                 DEF_MAC, 0, 0, 1);
        // R6: only the last byte is non-zero
        run_case(16'h8129, 16'h0000, 16'h0000, 16'h0100, 1, 0,
                 48'h000000000001, 1, 0, 0);
        // R2: stray acknowledges while idle or finished
        run_case(16'h8129, 16'h9A08, 16'hBCAB, 16'hDECD, 4, 1,
                 48'h089AABBCCDDE, 1, 0, 0);
        // R1: reset in the middle of the address reads, then a full run
        for (int i = 0; i < 16; i++) mem[i] = 16'h0000;
        mem[0] = 16'h8129;
        lat = 2; stray = 0;
        start_reset();
        repeat (6) @(negedge clk);
        run_case(16'h8129, 16'h5A00, 16'h0000, 16'hA500, 2, 0,
                 48'h005A000000A5, 1, 0, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule